// File: doc/BRIEF.md
# Indirect Register Access Port

This block is the host-side front end of a network controller's register file. The host sees two 16-byte windows: a control window and a station-address PROM window. The control window holds an address pointer. The host loads the pointer, then reaches one of 128 control/status words through one data port, or one of 32 bus-configuration words through a second data port. Reading a dedicated reset port performs a software reset.

The control window has two offset maps: a word map and a dword map. The active map is chosen by a mode bit in configuration word 18. A dword write to offset 0 while the word map is active sets that bit. The host can clear the bit again through the configuration data port. Any access whose size does not fit the active map is ignored. Reads of the data ports return data combinationally in the cycle of the read strobe. The interrupt output is re-evaluated after every access.

Top module: `regport_window`

## Requirements
- R1: After hardware reset, configuration word 18 holds 0x9001, word 2 holds 0x0002, word 4 holds 0x00C0, and all other configuration words are zero. All status words, the pointer and `irq` are zero. The word map is active, because the mode bit is bit 7 of word 18.
- R2: In the word map (size code 1), the offsets are: 0x0 status data, 0x2 pointer, 0x4 reset port, 0x6 configuration data. Reads return the word selected by the pointer, zero-extended, in the cycle of `rd_en`.
- R3: A pointer write keeps only the low 7 bits of the data. A pointer read returns the stored value.
- R4: A read of the reset port returns 0. At the clock edge of that read, all status words and the pointer are cleared. Configuration words and PROM bytes are kept, and a write to the reset port has no effect.
- R5: A dword write (size code 2) to offset 0 in the word map sets bit 7 of configuration word 18 and leaves its other bits unchanged. The write data is discarded, and the dword map becomes active.
- R6: In the dword map, the offsets are: 0x0 status data, 0x4 pointer, 0x8 reset port, 0xC configuration data. Writes use only data bits 15:0.
- R7: The following control-window accesses are ignored, and reads of them return 0xFFFFFFFF: byte or word accesses in the dword map; byte accesses, dword reads, and dword writes to any offset other than 0 in the word map; size code 3; and offsets that are not mapped.
- R8: When the pointer is 32 or more, the configuration data port reads 0 and ignores writes.
- R9: PROM window reads return 1, 2 or 4 bytes (size codes 0, 1, 2), little-endian, starting at the offset and wrapping modulo 16. Byte i resets to bits 8i+7:8i of parameter PROM_INIT.
- R10: A PROM write stores its bytes only while bit 7 of configuration word 2 is 1. Otherwise it is ignored.
- R11: `irq` takes the value (status word 0 bit 6) AND (OR of status word 0 bits 15:8). It is updated at the second clock edge after each access and holds between accesses.
- R12: Writing configuration word 18 through its data port with bit 7 clear returns the block to the word map.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe (ignored while rd_en is high) |
| prom_sel | input | 1 | 1 selects the PROM window, 0 the control window |
| addr | input | 4 | Byte offset within the selected window |
| size | input | 2 | Access size: 0 byte, 1 word, 2 dword, 3 reserved |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid in the cycle of rd_en, zero otherwise |
| irq | output | 1 | Interrupt request |

## Verification
The embedded assertions check the following on every cycle:
- reset-port reads return zero and all-ones is returned for mis-sized accesses;
- a mode-switch write raises the mode bit;
- a pointer write stores the low bits;
- a locked PROM write changes nothing;
- `irq` moves only after an access;
- an out-of-range configuration read returns zero.

Only the bench scenarios can show that data really reaches the selected word, that the pointer and status words are cleared by the reset read while configuration and PROM survive, that the PROM wraps across offset 15, and that the block can leave the dword map again. The random phase checks these against a bench model while the mode and lock bits change.

// File: rtl/regport_pkg.sv
package regport_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE  = 2'd0,
      SZ_WORD  = 2'd1,
      SZ_DWORD = 2'd2,
      SZ_RSVD  = 2'd3
   } acc_size_e;

   typedef enum logic [2:0] {
      K_NONE   = 3'd0,
      K_CSR    = 3'd1,
      K_PTR    = 3'd2,
      K_RST    = 3'd3,
      K_BCR    = 3'd4,
      K_MODESW = 3'd5,
      K_PROM   = 3'd6,
      K_BAD    = 3'd7
   } acc_kind_e;

   typedef struct packed {
      acc_kind_e kind;
      logic      rd;
      logic      wr;
   } acc_op_t;

   localparam logic [3:0] W16_CSR = 4'h0;
   localparam logic [3:0] W16_PTR = 4'h2;
   localparam logic [3:0] W16_RST = 4'h4;
   localparam logic [3:0] W16_BCR = 4'h6;
   localparam logic [3:0] W32_CSR = 4'h0;
   localparam logic [3:0] W32_PTR = 4'h4;
   localparam logic [3:0] W32_RST = 4'h8;
   localparam logic [3:0] W32_BCR = 4'hC;
   localparam logic [3:0] SWITCH_OFS = 4'h0;

endpackage

// File: rtl/regport_decode.sv
module regport_decode
   import regport_pkg::*;
#(
   parameter int ADDR_W     = 4,
   parameter bit PROM_MULTI = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  logic              wr_en,
   input  logic              prom_sel,
   input  logic [ADDR_W-1:0] addr,
   input  logic [1:0]        size,
   input  logic              dwio,
   output acc_op_t           op
);

   acc_size_e sz;
   acc_kind_e ctl_kind;
   acc_kind_e prom_kind;
   logic      any;

   assign sz  = acc_size_e'(size);
   assign any = rd_en | wr_en;

   generate
      if (ADDR_W != 4) begin : g_bad_addr
         $error("regport_decode: ADDR_W must be 4");
      end
      if (PROM_MULTI) begin : g_prom_multi
         assign prom_kind = (sz == SZ_RSVD) ? K_BAD : K_PROM;
      end else begin : g_prom_byte
         assign prom_kind = (sz == SZ_BYTE) ? K_PROM : K_BAD;
      end
   endgenerate

   always_comb begin
      ctl_kind = K_BAD;
      if (!dwio) begin
         if (sz == SZ_WORD) begin
            unique case (addr)
               W16_CSR: ctl_kind = K_CSR;
               W16_PTR: ctl_kind = K_PTR;
               W16_RST: ctl_kind = K_RST;
               W16_BCR: ctl_kind = K_BCR;
               default: ctl_kind = K_BAD;
            endcase
         end else if (sz == SZ_DWORD && !rd_en && addr == SWITCH_OFS) begin
            ctl_kind = K_MODESW;
         end
      end else if (sz == SZ_DWORD) begin
         unique case (addr)
            W32_CSR: ctl_kind = K_CSR;
            W32_PTR: ctl_kind = K_PTR;
            W32_RST: ctl_kind = K_RST;
            W32_BCR: ctl_kind = K_BCR;
            default: ctl_kind = K_BAD;
         endcase
      end
   end

   always_comb begin
      op.rd   = rd_en;
      op.wr   = wr_en & ~rd_en;
      op.kind = K_NONE;
      if (any) op.kind = prom_sel ? prom_kind : ctl_kind;
   end

   // R7: a register-port kind in the word map only comes from a word access
   assert_word_map_size_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!dwio && !prom_sel && op.kind inside {K_CSR, K_PTR, K_RST, K_BCR}) |-> (sz == SZ_WORD));

   // R6: in the dword map every register-port kind comes from a dword access
   assert_dword_map_size_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (dwio && !prom_sel && op.kind inside {K_CSR, K_PTR, K_RST, K_BCR}) |-> (sz == SZ_DWORD));

endmodule

// File: rtl/regport_regs.sv
module regport_regs
   import regport_pkg::*;
#(
   parameter int               CSR_COUNT = 128,
   parameter int               BCR_COUNT = 32,
   parameter int               REG_W     = 16,
   parameter int               MODE_REG  = 18,
   parameter int               MODE_BIT  = 7,
   parameter int               LOCK_REG  = 2,
   parameter int               LOCK_BIT  = 7,
   parameter int               LINK_REG  = 4,
   parameter logic [REG_W-1:0] MODE_RST  = 16'h9001,
   parameter logic [REG_W-1:0] LOCK_RST  = 16'h0002,
   parameter logic [REG_W-1:0] LINK_RST  = 16'h00C0,
   parameter int               IEN_BIT   = 6,
   parameter int               FLAG_LO   = 8,
   localparam int              PTR_W     = $clog2(CSR_COUNT),
   localparam int              BIDX_W    = $clog2(BCR_COUNT)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  acc_op_t          op,
   input  logic [REG_W-1:0] wdata,
   output logic [REG_W-1:0] csr_rd,
   output logic [REG_W-1:0] bcr_rd,
   output logic             bcr_hit,
   output logic [PTR_W-1:0] ptr,
   output logic             dwio,
   output logic             prom_we,
   output logic             irq
);

   localparam logic [PTR_W-1:0] BCR_LIM = PTR_W'(BCR_COUNT);

   generate
      if (CSR_COUNT != (1 << PTR_W)) begin : g_bad_csr
         $error("regport_regs: CSR_COUNT must be a power of two");
      end
      if (BCR_COUNT != (1 << BIDX_W) || BCR_COUNT >= CSR_COUNT) begin : g_bad_bcr
         $error("regport_regs: BCR_COUNT must be a power of two below CSR_COUNT");
      end
      if (MODE_REG >= BCR_COUNT || LOCK_REG >= BCR_COUNT || LINK_REG >= BCR_COUNT) begin : g_bad_idx
         $error("regport_regs: special register index out of range");
      end
      if (FLAG_LO >= REG_W || IEN_BIT >= REG_W || MODE_BIT >= REG_W) begin : g_bad_bit
         $error("regport_regs: bit position out of range");
      end
   endgenerate

   logic [REG_W-1:0]  csr_mem [CSR_COUNT];
   logic [REG_W-1:0]  bcr_mem [BCR_COUNT];
   logic [PTR_W-1:0]  ptr_q;
   logic [BIDX_W-1:0] bcr_idx;
   logic              soft_rst;
   logic              csr_wr;
   logic              ptr_wr;
   logic              bcr_wr;
   logic              mode_set;
   logic              upd_q;
   logic              irq_q;
   logic [REG_W-1:0]  csr0;

   assign soft_rst = op.rd && (op.kind == K_RST);
   assign csr_wr   = op.wr && (op.kind == K_CSR);
   assign ptr_wr   = op.wr && (op.kind == K_PTR);
   assign mode_set = op.wr && (op.kind == K_MODESW);
   assign bcr_idx  = ptr_q[BIDX_W-1:0];
   assign bcr_hit  = (ptr_q < BCR_LIM);
   assign bcr_wr   = op.wr && (op.kind == K_BCR) && bcr_hit;

   // status words and pointer: cleared by hardware and software reset
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < CSR_COUNT; i++) csr_mem[i] <= '0;
         ptr_q <= '0;
      end else if (soft_rst) begin
         for (int i = 0; i < CSR_COUNT; i++) csr_mem[i] <= '0;
         ptr_q <= '0;
      end else begin
         if (csr_wr) csr_mem[ptr_q] <= wdata;
         if (ptr_wr) ptr_q <= wdata[PTR_W-1:0];
      end
   end

   // configuration words: each with its own reset value, untouched by soft reset
   generate
      for (genvar g = 0; g < BCR_COUNT; g++) begin : g_bcr
         localparam logic [REG_W-1:0] RV =
            (g == MODE_REG) ? MODE_RST :
            (g == LOCK_REG) ? LOCK_RST :
            (g == LINK_REG) ? LINK_RST : '0;
         localparam bit IS_MODE = (g == MODE_REG);
         logic [REG_W-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= RV;
            else if (bcr_wr && bcr_idx == BIDX_W'(g)) q <= wdata;
            else if (IS_MODE && mode_set) q[MODE_BIT] <= 1'b1;
         end
         assign bcr_mem[g] = q;
      end
   endgenerate

   assign csr0 = csr_mem[0];

   // interrupt: re-evaluated on the edge after the access commits
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         upd_q <= 1'b0;
         irq_q <= 1'b0;
      end else begin
         upd_q <= (op.kind != K_NONE);
         if (upd_q) irq_q <= csr0[IEN_BIT] & (|csr0[REG_W-1:FLAG_LO]);
      end
   end

   assign csr_rd  = csr_mem[ptr_q];
   assign bcr_rd  = bcr_hit ? bcr_mem[bcr_idx] : '0;
   assign ptr     = ptr_q;
   assign dwio    = bcr_mem[MODE_REG][MODE_BIT];
   assign prom_we = bcr_mem[LOCK_REG][LOCK_BIT];
   assign irq     = irq_q;

   // R3: a pointer write keeps the low pointer bits of the data
   assert_ptr_low_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ptr_wr |=> (ptr_q == $past(wdata[PTR_W-1:0])));

   // R4: a reset-port read leaves the pointer at zero
   assert_soft_reset_ptr_R4: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (ptr_q == '0));

   // R5: the mode-switch write raises the mode bit
   assert_mode_switch_R5: assert property (@(posedge clk) disable iff (!rst_n)
      mode_set |=> dwio);

   // R11: irq does not move unless an access happened on the previous cycle
   assert_irq_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_q |=> $stable(irq_q));

endmodule

// File: rtl/regport_prom.sv
module regport_prom
   import regport_pkg::*;
#(
   parameter int                   BYTES = 16,
   parameter logic [BYTES*8-1:0]   INIT  = '0,
   localparam int                  AW    = $clog2(BYTES),
   localparam int                  LANES = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  acc_op_t          op,
   input  logic [AW-1:0]    addr,
   input  logic [1:0]       size,
   input  logic [31:0]      wdata,
   input  logic             we_en,
   output logic [31:0]      rdata
);

   generate
      if (BYTES != (1 << AW) || BYTES < LANES) begin : g_bad_bytes
         $error("regport_prom: BYTES must be a power of two of at least 4");
      end
   endgenerate

   logic [BYTES-1:0][7:0] mem;
   logic [LANES-1:0][7:0] lane_rd;
   logic [2:0]            nb;
   logic                  do_wr;

   always_comb begin
      unique case (acc_size_e'(size))
         SZ_BYTE: nb = 3'd1;
         SZ_WORD: nb = 3'd2;
         default: nb = 3'd4;
      endcase
   end

   assign do_wr = op.wr && (op.kind == K_PROM) && we_en;

   generate
      for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
         logic [AW-1:0] la;
         assign la          = addr + AW'(ln);
         assign lane_rd[ln] = (3'(ln) < nb) ? mem[la] : 8'h00;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem <= INIT;
      end else if (do_wr) begin
         for (int l = 0; l < LANES; l++) begin
            if (3'(l) < nb) mem[addr + AW'(l)] <= wdata[8*l +: 8];
         end
      end
   end

   assign rdata = lane_rd;

   // R10: a PROM write while locked changes no byte
   assert_prom_locked_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (op.wr && op.kind == K_PROM && !we_en) |=> $stable(mem));

endmodule

// File: rtl/regport_window.sv
module regport_window
   import regport_pkg::*;
#(
   parameter int                  ADDR_W     = 4,
   parameter int                  DATA_W     = 32,
   parameter int                  REG_W      = 16,
   parameter int                  CSR_COUNT  = 128,
   parameter int                  BCR_COUNT  = 32,
   parameter int                  PROM_BYTES = 16,
   parameter bit                  PROM_MULTI = 1'b1,
   parameter logic [PROM_BYTES*8-1:0] PROM_INIT = 128'h0000_0000_0000_0000_0000_0000_0000_0000,
   localparam int                 PTR_W      = $clog2(CSR_COUNT),
   localparam int                 PROM_AW    = $clog2(PROM_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  logic              wr_en,
   input  logic              prom_sel,
   input  logic [ADDR_W-1:0] addr,
   input  logic [1:0]        size,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              irq
);

   generate
      if (DATA_W != 32 || REG_W != 16) begin : g_bad_width
         $error("regport_window: DATA_W must be 32 and REG_W 16");
      end
      if (PROM_AW != ADDR_W) begin : g_bad_prom
         $error("regport_window: PROM window must span the address width");
      end
   endgenerate

   acc_op_t          op;
   logic             dwio;
   logic             prom_we;
   logic             bcr_hit;
   logic [REG_W-1:0] csr_rd;
   logic [REG_W-1:0] bcr_rd;
   logic [PTR_W-1:0] ptr;
   logic [31:0]      prom_rd;

   regport_decode #(
      .ADDR_W     (ADDR_W),
      .PROM_MULTI (PROM_MULTI)
   ) u_decode (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_en    (rd_en),
      .wr_en    (wr_en),
      .prom_sel (prom_sel),
      .addr     (addr),
      .size     (size),
      .dwio     (dwio),
      .op       (op)
   );

   regport_regs #(
      .CSR_COUNT (CSR_COUNT),
      .BCR_COUNT (BCR_COUNT),
      .REG_W     (REG_W)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .op      (op),
      .wdata   (wdata[REG_W-1:0]),
      .csr_rd  (csr_rd),
      .bcr_rd  (bcr_rd),
      .bcr_hit (bcr_hit),
      .ptr     (ptr),
      .dwio    (dwio),
      .prom_we (prom_we),
      .irq     (irq)
   );

   regport_prom #(
      .BYTES (PROM_BYTES),
      .INIT  (PROM_INIT)
   ) u_prom (
      .clk   (clk),
      .rst_n (rst_n),
      .op    (op),
      .addr  (addr[PROM_AW-1:0]),
      .size  (size),
      .wdata (wdata),
      .we_en (prom_we),
      .rdata (prom_rd)
   );

   always_comb begin
      rdata = '0;
      if (op.rd) begin
         unique case (op.kind)
            K_CSR:   rdata = {{(DATA_W-REG_W){1'b0}}, csr_rd};
            K_PTR:   rdata = {{(DATA_W-PTR_W){1'b0}}, ptr};
            K_BCR:   rdata = {{(DATA_W-REG_W){1'b0}}, bcr_rd};
            K_PROM:  rdata = prom_rd;
            K_BAD:   rdata = '1;
            default: rdata = '0;
         endcase
      end
   end

   // R4: the reset port always reads zero
   assert_reset_read_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && op.kind == K_RST) |-> (rdata == '0));

   // R7: mis-sized or unmapped control accesses read all ones
   assert_bad_read_ones_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && op.kind == K_BAD) |-> (rdata == '1));

   // R8: configuration port with the pointer out of range reads zero
   assert_bcr_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && op.kind == K_BCR && !bcr_hit) |-> (rdata == '0));

   // R2: without a read strobe the read bus is idle
   assert_idle_rdata_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |-> (rdata == '0));

endmodule

// File: tb/regport_window_tb.sv
module regport_window_tb;

   localparam logic [127:0] PINIT = 128'hF0E1D2C3_B4A59687_78695A4B_3C2D1E0F;
   localparam int KN = 0, KC = 1, KP = 2, KR = 3, KB = 4, KM = 5, KPR = 6, KX = 7;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rd_en = 1'b0;
   logic        wr_en = 1'b0;
   logic        prom_sel = 1'b0;
   logic [3:0]  addr = '0;
   logic [1:0]  size = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [15:0] csr_m [128];
   logic [15:0] bcr_m [32];
   logic [7:0]  prom_m [16];
   logic [6:0]  rap_m;
   logic [31:0] last_rd;

   regport_window #(.PROM_INIT(PINIT)) u_dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_en    (rd_en),
      .wr_en    (wr_en),
      .prom_sel (prom_sel),
      .addr     (addr),
      .size     (size),
      .wdata    (wdata),
      .rdata    (rdata),
      .irq      (irq)
   );

   always #5 clk = ~clk;

   task automatic check(input logic [31:0] got, input logic [31:0] exp, input string tag);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got=%08h exp=%08h", tag, got, exp);
      end
   endtask

   function automatic int classify(bit r, bit ps, logic [3:0] a, logic [1:0] sz);
      bit dw = bcr_m[18][7];
      if (ps) return (sz == 2'd3) ? KX : KPR;
      if (!dw) begin
         if (sz == 2'd1) begin
            case (a)
               4'h0: return KC;
               4'h2: return KP;
               4'h4: return KR;
               4'h6: return KB;
               default: return KX;
            endcase
         end
         if (sz == 2'd2 && !r && a == 4'h0) return KM;
         return KX;
      end
      if (sz != 2'd2) return KX;
      case (a)
         4'h0: return KC;
         4'h4: return KP;
         4'h8: return KR;
         4'hC: return KB;
         default: return KX;
      endcase
   endfunction

   function automatic logic [31:0] model_read(int k, logic [3:0] a, logic [1:0] sz);
      logic [31:0] v = '0;
      int nb = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
      case (k)
         KC: v = {16'h0, csr_m[rap_m]};
         KP: v = {25'h0, rap_m};
         KB: v = (rap_m < 7'd32) ? {16'h0, bcr_m[rap_m[4:0]]} : 32'h0;
         KPR: for (int l = 0; l < nb; l++) v[8*l +: 8] = prom_m[(a + l) % 16];
         KX: v = 32'hFFFF_FFFF;
         default: v = '0;
      endcase
      return v;
   endfunction

   function automatic string tag_of(int k, bit r);
      case (k)
         KC: return bcr_m[18][7] ? "R6" : "R2";
         KP: return "R3";
         KR: return "R4";
         KB: return (rap_m >= 7'd32) ? "R8" : (bcr_m[18][7] ? "R6" : "R2");
         KM: return "R5";
         KPR: return r ? "R9" : "R10";
         default: return "R7";
      endcase
   endfunction

   task automatic model_apply(int k, bit r, logic [3:0] a, logic [1:0] sz, logic [31:0] wd);
      int nb = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
      if (r) begin
         if (k == KR) begin
            for (int i = 0; i < 128; i++) csr_m[i] = '0;
            rap_m = '0;
         end
      end else begin
         case (k)
            KC: csr_m[rap_m] = wd[15:0];
            KP: rap_m = wd[6:0];
            KB: if (rap_m < 7'd32) bcr_m[rap_m[4:0]] = wd[15:0];
            KM: bcr_m[18][7] = 1'b1;
            KPR: if (bcr_m[2][7]) for (int l = 0; l < nb; l++) prom_m[(a + l) % 16] = wd[8*l +: 8];
            default: ;
         endcase
      end
   endtask

   function automatic logic exp_irq();
      return csr_m[0][6] & (|csr_m[0][15:8]);
   endfunction

   task automatic acc(input bit r, input bit ps, input logic [3:0] a, input logic [1:0] sz,
                      input logic [31:0] wd, input string tag);
      int k;
      logic [31:0] exp;
      logic [31:0] got;
      string t;
      k = classify(r, ps, a, sz);
      exp = model_read(k, a, sz);
      t = (tag == "") ? tag_of(k, r) : tag;
      @(negedge clk);
      rd_en = r; wr_en = ~r; prom_sel = ps; addr = a; size = sz; wdata = wd;
      #1 got = rdata;
      if (r) check(got, exp, t);
      last_rd = got;
      @(negedge clk);
      rd_en = 1'b0; wr_en = 1'b0;
      model_apply(k, r, a, sz, wd);
      @(negedge clk);
      check({31'h0, irq}, {31'h0, exp_irq()}, "R11");
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      for (int i = 0; i < 128; i++) csr_m[i] = '0;
      for (int i = 0; i < 32; i++) bcr_m[i] = '0;
      bcr_m[18] = 16'h9001; bcr_m[2] = 16'h0002; bcr_m[4] = 16'h00C0;
      for (int i = 0; i < 16; i++) prom_m[i] = PINIT[8*i +: 8];
      rap_m = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      check({31'h0, irq}, 32'h0, "R1");
      check(rdata, 32'h0, "R1");
      acc(1, 0, 4'h2, 2'd1, 0, "R1");
      check(last_rd, 32'h0, "R1");
      acc(0, 0, 4'h2, 2'd1, 32'd18, "R1");
      acc(1, 0, 4'h6, 2'd1, 0, "R1");
      check(last_rd, 32'h0000_9001, "R1");
      acc(0, 0, 4'h2, 2'd1, 32'd2, "R1");
      acc(1, 0, 4'h6, 2'd1, 0, "R1");
      acc(0, 0, 4'h2, 2'd1, 32'd4, "R1");
      acc(1, 0, 4'h6, 2'd1, 0, "R1");
      check(last_rd, 32'h0000_00C0, "R1");

      // R3: pointer keeps 7 bits
      acc(0, 0, 4'h2, 2'd1, 32'h0000_01A5, "R3");
      acc(1, 0, 4'h2, 2'd1, 0, "R3");
      check(last_rd, 32'h0000_0025, "R3");

      // R2: status word through the word map
      acc(0, 0, 4'h2, 2'd1, 32'd5, "R2");
      acc(0, 0, 4'h0, 2'd1, 32'h5555_1234, "R2");
      acc(1, 0, 4'h0, 2'd1, 0, "R2");
      check(last_rd, 32'h0000_1234, "R2");

      // R7: wrong sizes in the word map
      acc(1, 0, 4'h0, 2'd0, 0, "R7");
      acc(1, 0, 4'h0, 2'd2, 0, "R7");
      acc(0, 0, 4'h4, 2'd2, 32'h0000_0077, "R7");
      acc(1, 0, 4'h2, 2'd1, 0, "R7");
      check(last_rd, 32'h0000_0005, "R7");
      acc(1, 0, 4'hA, 2'd1, 0, "R7");

      // R11: interrupt from status word 0
      acc(0, 0, 4'h2, 2'd1, 32'd0, "R11");
      acc(0, 0, 4'h0, 2'd1, 32'h0000_0140, "R11");
      check({31'h0, irq}, 32'h1, "R11");
      acc(0, 0, 4'h0, 2'd1, 32'h0000_0100, "R11");
      check({31'h0, irq}, 32'h0, "R11");

      // R9: PROM wrap
      acc(1, 1, 4'hF, 2'd1, 0, "R9");
      check(last_rd, 32'h0000_0FF0, "R9");
      acc(1, 1, 4'hE, 2'd2, 0, "R9");

      // R10: locked then unlocked
      acc(0, 1, 4'h3, 2'd0, 32'h0000_00AA, "R10");
      acc(1, 1, 4'h3, 2'd0, 0, "R10");
      check(last_rd, 32'h0000_003C, "R10");
      acc(0, 0, 4'h2, 2'd1, 32'd2, "R10");
      acc(0, 0, 4'h6, 2'd1, 32'h0000_0082, "R10");
      acc(0, 1, 4'h3, 2'd0, 32'h0000_00AA, "R10");
      acc(1, 1, 4'h3, 2'd0, 0, "R10");
      check(last_rd, 32'h0000_00AA, "R10");

      // R8: configuration pointer out of range
      acc(0, 0, 4'h2, 2'd1, 32'd40, "R8");
      acc(0, 0, 4'h6, 2'd1, 32'h0000_BEEF, "R8");
      acc(1, 0, 4'h6, 2'd1, 0, "R8");
      check(last_rd, 32'h0, "R8");
      acc(0, 0, 4'h2, 2'd1, 32'd8, "R8");
      acc(1, 0, 4'h6, 2'd1, 0, "R8");
      check(last_rd, 32'h0, "R8");

      // R4: reset port
      acc(0, 0, 4'h2, 2'd1, 32'd10, "R4");
      acc(0, 0, 4'h0, 2'd1, 32'h0000_4321, "R4");
      acc(0, 0, 4'h4, 2'd1, 32'h0000_FFFF, "R4");
      acc(1, 0, 4'h0, 2'd1, 0, "R4");
      check(last_rd, 32'h0000_4321, "R4");
      acc(1, 0, 4'h4, 2'd1, 0, "R4");
      check(last_rd, 32'h0, "R4");
      acc(1, 0, 4'h2, 2'd1, 0, "R4");
      check(last_rd, 32'h0, "R4");
      acc(0, 0, 4'h2, 2'd1, 32'd2, "R4");
      acc(1, 0, 4'h6, 2'd1, 0, "R4");
      check(last_rd, 32'h0000_0082, "R4");

      // R5: switch to the dword map
      acc(0, 0, 4'h0, 2'd2, 32'h1234_0000, "R5");
      acc(1, 0, 4'h2, 2'd1, 0, "R5");
      check(last_rd, 32'hFFFF_FFFF, "R5");
      acc(0, 0, 4'h4, 2'd2, 32'd18, "R5");
      acc(1, 0, 4'hC, 2'd2, 0, "R5");
      check(last_rd, 32'h0000_9081, "R5");

      // R6: dword map
      acc(0, 0, 4'h4, 2'd2, 32'hABCD_0012, "R6");
      acc(1, 0, 4'h4, 2'd2, 0, "R6");
      check(last_rd, 32'h0000_0012, "R6");
      acc(0, 0, 4'h0, 2'd2, 32'hDEAD_BEEF, "R6");
      acc(1, 0, 4'h0, 2'd2, 0, "R6");
      check(last_rd, 32'h0000_BEEF, "R6");
      acc(1, 0, 4'h0, 2'd1, 0, "R7");
      acc(1, 0, 4'h8, 2'd2, 0, "R4");
      check(last_rd, 32'h0, "R4");

      // R12: leave the dword map
      acc(0, 0, 4'h4, 2'd2, 32'd18, "R12");
      acc(0, 0, 4'hC, 2'd2, 32'hFFFF_9001, "R12");
      acc(1, 0, 4'h2, 2'd1, 0, "R12");
      check(last_rd, 32'd18, "R12");

      // random phase against the model
      for (int n = 0; n < 1500; n++) begin
         bit          ps = ($urandom % 4) == 0;
         bit          dw = bcr_m[18][7];
         bit          r  = ($urandom % 10) < 6;
         logic [1:0]  sz;
         logic [3:0]  a;
         logic [31:0] wd = $urandom;
         if (($urandom % 10) < 8) sz = ps ? 2'($urandom % 3) : (dw ? 2'd2 : 2'd1);
         else sz = 2'($urandom % 4);
         if (ps || ($urandom % 8) == 0) a = 4'($urandom % 16);
         else a = dw ? 4'(4 * ($urandom % 4)) : 4'(2 * ($urandom % 4));
         if (!ps && classify(r, ps, a, sz) == KP && ($urandom % 2)) wd = $urandom % 40;
         if (r && classify(r, ps, a, sz) == KR && ($urandom % 4) != 0) r = 1'b0;
         acc(r, ps, a, sz, wd, "");
      end

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule